// File: doc/BRIEF.md
# Low-Power DDR Command Front End

This block sits at the command pins of a four-bank low-power DDR memory, on the device side. On every rising clock edge it samples chip select, the three command strobes, the bank-address pair, a 13-bit address bus and clock enable. It turns the pin pattern into one-cycle command pulses and keeps track of which banks hold an open row and which row that is. A scheduled auto-precharge closes its bank once the burst is over. It also sorts the memory into running, precharge power-down, active power-down or self refresh whenever clock enable drops.

Every output is registered. A command sampled at edge k shows on the outputs just after edge k. The decoded bank, the full address, the column and the A10 flag are held until the next executed command. The register-set command is split into two strobes: one for the mode register and one for the extended mode register. The burst-length field of the mode register sets how long auto-precharge waits.

Top module: `lpddr_cmd_front`

## Requirements
- R1: With chip select low and the block running, {RAS#,CAS#,WE#} = 011 gives ACTIVE, 101 READ, 100 WRITE, 010 PRECHARGE, 001 REFRESH and 000 register-set. Other patterns do nothing. A legal command gives exactly one pulse on its own output after the sampling edge, and at most one command pulse is high at a time.
- R2: A cycle with chip select high gives no pulse and leaves the bank state and the held fields unchanged.
- R3: ACTIVE to an idle bank sets that bank's bit in bank_open_o and stores the 13-bit address as its row in open_rows_o (bank b at bits 13*b+12:13*b). A closed bank keeps showing its last row.
- R4: Any executed command other than a no-op loads cmd_bank_o from BA, cmd_addr_o from A12:A0, cmd_col_o from A8:A0 and cmd_ap_o from A10.
- R5: PRECHARGE with A10 low closes only the bank named by BA. With A10 high it closes all banks.
- R6: READ or WRITE with A10 high to an open bank closes that bank N edges after the sampling edge. N is 1, 2 or 4 when the mode-register field A2:A0 is 1, 2 or 3, and 1 for any other value. After reset the field is 1.
- R7: A register-set command with BA1 low pulses mr_wr_o, and with BA1 high it pulses emr_wr_o. The op-code appears on cmd_addr_o. Only the mode-register write changes the burst field.
- R8: READ or WRITE to an idle bank, or ACTIVE to an open bank, pulses illegal_o instead of the command pulse and changes no bank state.
- R9: Clock enable sampled low while running with all banks idle and no REFRESH pattern enters precharge power-down (pd_pre_o).
- R10: Clock enable sampled low together with a REFRESH pattern while all banks are idle enters self refresh (self_ref_o).
- R11: Clock enable sampled low while running with any bank open enters active power-down (pd_act_o), whatever the command pins show.
- R12: In any low-power state no command is executed. The first edge with clock enable high returns to running, and the command sampled on that edge is also ignored.
- R13: After reset all pulses, flags, bank bits, rows and held fields are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cke_i | input | 1 | Clock enable |
| cs_n_i | input | 1 | Chip select, active low |
| ras_n_i | input | 1 | Row strobe, active low |
| cas_n_i | input | 1 | Column strobe, active low |
| we_n_i | input | 1 | Write enable, active low |
| ba_i | input | 2 | Bank address |
| addr_i | input | 13 | Address / op-code bus |
| act_o | output | 1 | ACTIVE pulse |
| rd_o | output | 1 | READ pulse |
| wr_o | output | 1 | WRITE pulse |
| pre_o | output | 1 | PRECHARGE pulse |
| ref_o | output | 1 | REFRESH pulse |
| mr_wr_o | output | 1 | Mode register write strobe |
| emr_wr_o | output | 1 | Extended mode register write strobe |
| illegal_o | output | 1 | Illegal command pulse |
| cmd_bank_o | output | 2 | Bank of last executed command |
| cmd_addr_o | output | 13 | Address/op-code of last executed command |
| cmd_col_o | output | 9 | Column of last executed command |
| cmd_ap_o | output | 1 | A10 of last executed command |
| bank_open_o | output | 4 | Per-bank open bit |
| open_rows_o | output | 52 | Per-bank row, 13 bits each |
| pd_pre_o | output | 1 | Precharge power-down |
| pd_act_o | output | 1 | Active power-down |
| self_ref_o | output | 1 | Self refresh |

## Verification
Directed steps go through each command pattern first, then the two precharge scopes, auto-precharge with a 4-cycle burst, and both register-set targets. They also drive clock enable low in three situations: banks idle with no refresh, banks idle with refresh, and a bank open. Those three cases separate the three low-power states and show that commands on the exit edge are dropped. A long random run then mixes every pin pattern with random banks, addresses, chip-select gaps and clock-enable drops. This reaches illegal pairs, reloads of an auto-precharge countdown and precharges that race it. The random patterns are checked against a bench model built from the requirements.

// File: rtl/lpddr_cmd_pkg.sv
package lpddr_cmd_pkg;

  typedef enum logic [2:0] {
    CMD_NOP,
    CMD_ACT,
    CMD_RD,
    CMD_WR,
    CMD_PRE,
    CMD_REF,
    CMD_MRS
  } cmd_e;

  typedef enum logic [1:0] {
    PWR_RUN,
    PWR_PPD,
    PWR_APD,
    PWR_SREF
  } pwr_e;

  // Pin pattern to command; chip select high is a deselect (no-op).
  function automatic cmd_e pins_to_cmd(input logic cs_n, input logic ras_n,
                                       input logic cas_n, input logic we_n);
    cmd_e c;
    c = CMD_NOP;
    if (!cs_n) begin
      case ({ras_n, cas_n, we_n})
        3'b011:  c = CMD_ACT;
        3'b101:  c = CMD_RD;
        3'b100:  c = CMD_WR;
        3'b010:  c = CMD_PRE;
        3'b001:  c = CMD_REF;
        3'b000:  c = CMD_MRS;
        default: c = CMD_NOP;
      endcase
    end
    return c;
  endfunction

  // Burst field of the mode register to clock cycles of data transfer.
  function automatic int burst_cycles(input logic [2:0] code);
    case (code)
      3'd2:    return 2;
      3'd3:    return 4;
      default: return 1;
    endcase
  endfunction

endpackage

// File: rtl/lpddr_cmd_decode.sv
module lpddr_cmd_decode
  import lpddr_cmd_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int BA_W      = $clog2(NUM_BANKS)
) (
  input  logic                 exec_i,
  input  logic                 cs_n_i,
  input  logic                 ras_n_i,
  input  logic                 cas_n_i,
  input  logic                 we_n_i,
  input  logic [BA_W-1:0]      ba_i,
  input  logic                 ap_bit_i,
  input  logic [NUM_BANKS-1:0] bank_open_i,
  output cmd_e                 raw_cmd_o,
  output cmd_e                 cmd_o,
  output logic                 illegal_o,
  output logic [NUM_BANKS-1:0] act_mask_o,
  output logic [NUM_BANKS-1:0] close_mask_o,
  output logic [NUM_BANKS-1:0] ap_mask_o
);

  logic tgt_open;
  logic is_rw;

  always_comb begin
    raw_cmd_o = pins_to_cmd(cs_n_i, ras_n_i, cas_n_i, we_n_i);
    cmd_o     = exec_i ? raw_cmd_o : CMD_NOP;
    tgt_open  = bank_open_i[ba_i];
    is_rw     = (cmd_o == CMD_RD) || (cmd_o == CMD_WR);
    illegal_o = ((cmd_o == CMD_ACT) && tgt_open) || (is_rw && !tgt_open);
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_mask
    logic sel;
    assign sel             = (ba_i == BA_W'(b));
    assign act_mask_o[b]   = (cmd_o == CMD_ACT) && !illegal_o && sel;
    assign close_mask_o[b] = (cmd_o == CMD_PRE) && (ap_bit_i || sel);
    assign ap_mask_o[b]    = is_rw && !illegal_o && ap_bit_i && sel;
  end

endmodule

// File: rtl/lpddr_bank_slot.sv
module lpddr_bank_slot #(
  parameter int ROW_W = 13,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             act_i,
  input  logic             close_i,
  input  logic             ap_i,
  input  logic [ROW_W-1:0] row_i,
  input  logic [CNT_W-1:0] burst_i,
  output logic             open_o,
  output logic [ROW_W-1:0] row_o
);

  logic [CNT_W-1:0] ap_cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      open_o   <= 1'b0;
      row_o    <= '0;
      ap_cnt_q <= '0;
    end else if (act_i) begin
      open_o   <= 1'b1;
      row_o    <= row_i;
      ap_cnt_q <= '0;
    end else if (close_i) begin
      open_o   <= 1'b0;
      ap_cnt_q <= '0;
    end else if (ap_i) begin
      ap_cnt_q <= burst_i;
    end else if (ap_cnt_q != '0) begin
      if (ap_cnt_q == CNT_W'(1)) open_o <= 1'b0;
      ap_cnt_q <= ap_cnt_q - CNT_W'(1);
    end
  end

endmodule

// File: rtl/lpddr_pwr_fsm.sv
module lpddr_pwr_fsm
  import lpddr_cmd_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic cke_i,
  input  logic ref_req_i,
  input  logic any_open_i,
  output logic run_o,
  output logic pd_pre_o,
  output logic pd_act_o,
  output logic self_ref_o
);

  pwr_e st_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= PWR_RUN;
    end else begin
      case (st_q)
        PWR_RUN: begin
          if (!cke_i) begin
            if (any_open_i)     st_q <= PWR_APD;
            else if (ref_req_i) st_q <= PWR_SREF;
            else                st_q <= PWR_PPD;
          end
        end
        default: begin
          if (cke_i) st_q <= PWR_RUN;
        end
      endcase
    end
  end

  assign run_o      = (st_q == PWR_RUN);
  assign pd_pre_o   = (st_q == PWR_PPD);
  assign pd_act_o   = (st_q == PWR_APD);
  assign self_ref_o = (st_q == PWR_SREF);

endmodule

// File: rtl/lpddr_cmd_front.sv
module lpddr_cmd_front
  import lpddr_cmd_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int BA_W      = $clog2(NUM_BANKS),
  parameter int ROW_W     = 13,
  parameter int COL_W     = 9,
  parameter int AP_BIT    = 10,
  parameter int CNT_W     = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       cke_i,
  input  logic                       cs_n_i,
  input  logic                       ras_n_i,
  input  logic                       cas_n_i,
  input  logic                       we_n_i,
  input  logic [BA_W-1:0]            ba_i,
  input  logic [ROW_W-1:0]           addr_i,
  output logic                       act_o,
  output logic                       rd_o,
  output logic                       wr_o,
  output logic                       pre_o,
  output logic                       ref_o,
  output logic                       mr_wr_o,
  output logic                       emr_wr_o,
  output logic                       illegal_o,
  output logic [BA_W-1:0]            cmd_bank_o,
  output logic [ROW_W-1:0]           cmd_addr_o,
  output logic [COL_W-1:0]           cmd_col_o,
  output logic                       cmd_ap_o,
  output logic [NUM_BANKS-1:0]       bank_open_o,
  output logic [NUM_BANKS*ROW_W-1:0] open_rows_o,
  output logic                       pd_pre_o,
  output logic                       pd_act_o,
  output logic                       self_ref_o
);

  localparam int BL_W = 3;

  cmd_e                 raw_cmd_w;
  cmd_e                 cmd_w;
  logic                 ill_w;
  logic                 run_w;
  logic                 exec_w;
  logic                 ext_sel_w;
  logic [NUM_BANKS-1:0] open_w;
  logic [NUM_BANKS-1:0] act_m;
  logic [NUM_BANKS-1:0] close_m;
  logic [NUM_BANKS-1:0] ap_m;
  logic [BL_W-1:0]      bl_q;
  logic [CNT_W-1:0]     burst_w;

  assign exec_w    = run_w & cke_i;
  assign ext_sel_w = ba_i[BA_W-1];
  assign burst_w   = CNT_W'(burst_cycles(bl_q));

  lpddr_cmd_decode #(
    .NUM_BANKS (NUM_BANKS),
    .BA_W      (BA_W)
  ) decode_i (
    .exec_i       (exec_w),
    .cs_n_i       (cs_n_i),
    .ras_n_i      (ras_n_i),
    .cas_n_i      (cas_n_i),
    .we_n_i       (we_n_i),
    .ba_i         (ba_i),
    .ap_bit_i     (addr_i[AP_BIT]),
    .bank_open_i  (open_w),
    .raw_cmd_o    (raw_cmd_w),
    .cmd_o        (cmd_w),
    .illegal_o    (ill_w),
    .act_mask_o   (act_m),
    .close_mask_o (close_m),
    .ap_mask_o    (ap_m)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    lpddr_bank_slot #(
      .ROW_W (ROW_W),
      .CNT_W (CNT_W)
    ) slot_i (
      .clk     (clk),
      .rst     (rst),
      .act_i   (act_m[b]),
      .close_i (close_m[b]),
      .ap_i    (ap_m[b]),
      .row_i   (addr_i),
      .burst_i (burst_w),
      .open_o  (open_w[b]),
      .row_o   (open_rows_o[b*ROW_W +: ROW_W])
    );
  end

  assign bank_open_o = open_w;

  lpddr_pwr_fsm pwr_i (
    .clk        (clk),
    .rst        (rst),
    .cke_i      (cke_i),
    .ref_req_i  (raw_cmd_w == CMD_REF),
    .any_open_i (|open_w),
    .run_o      (run_w),
    .pd_pre_o   (pd_pre_o),
    .pd_act_o   (pd_act_o),
    .self_ref_o (self_ref_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      act_o      <= 1'b0;
      rd_o       <= 1'b0;
      wr_o       <= 1'b0;
      pre_o      <= 1'b0;
      ref_o      <= 1'b0;
      mr_wr_o    <= 1'b0;
      emr_wr_o   <= 1'b0;
      illegal_o  <= 1'b0;
      cmd_bank_o <= '0;
      cmd_addr_o <= '0;
      cmd_col_o  <= '0;
      cmd_ap_o   <= 1'b0;
      bl_q       <= BL_W'(1);
    end else begin
      act_o     <= (cmd_w == CMD_ACT) && !ill_w;
      rd_o      <= (cmd_w == CMD_RD)  && !ill_w;
      wr_o      <= (cmd_w == CMD_WR)  && !ill_w;
      pre_o     <= (cmd_w == CMD_PRE);
      ref_o     <= (cmd_w == CMD_REF);
      mr_wr_o   <= (cmd_w == CMD_MRS) && !ext_sel_w;
      emr_wr_o  <= (cmd_w == CMD_MRS) && ext_sel_w;
      illegal_o <= ill_w;
      if (cmd_w != CMD_NOP) begin
        cmd_bank_o <= ba_i;
        cmd_addr_o <= addr_i;
        cmd_col_o  <= addr_i[COL_W-1:0];
        cmd_ap_o   <= addr_i[AP_BIT];
      end
      if ((cmd_w == CMD_MRS) && !ext_sel_w) bl_q <= addr_i[BL_W-1:0];
    end
  end

endmodule

// File: rtl/lpddr_cmd_front_chk.sv
module lpddr_cmd_front_chk #(
  parameter int NUM_BANKS = 4,
  parameter int BA_W      = $clog2(NUM_BANKS)
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 cs_n_i,
  input logic                 act_o,
  input logic                 rd_o,
  input logic                 wr_o,
  input logic                 pre_o,
  input logic                 ref_o,
  input logic                 mr_wr_o,
  input logic                 emr_wr_o,
  input logic                 illegal_o,
  input logic [BA_W-1:0]      cmd_bank_o,
  input logic                 cmd_ap_o,
  input logic [NUM_BANKS-1:0] bank_open_o,
  input logic                 pd_pre_o,
  input logic                 pd_act_o,
  input logic                 self_ref_o
);

  logic any_pulse;
  logic low_pwr;
  assign any_pulse = act_o | rd_o | wr_o | pre_o | ref_o | mr_wr_o | emr_wr_o | illegal_o;
  assign low_pwr   = pd_pre_o | pd_act_o | self_ref_o;

  assert_one_cmd_R1: assert property (@(posedge clk) disable iff (rst)
    $onehot0({act_o, rd_o, wr_o, pre_o, ref_o, mr_wr_o, emr_wr_o, illegal_o}));

  assert_deselect_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    cs_n_i |=> !any_pulse);

  assert_act_opens_R3: assert property (@(posedge clk) disable iff (rst)
    act_o |-> bank_open_o[cmd_bank_o]);

  assert_pre_all_idle_R5: assert property (@(posedge clk) disable iff (rst)
    (pre_o && cmd_ap_o) |-> (bank_open_o == '0));

  assert_one_pwr_state_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot0({pd_pre_o, pd_act_o, self_ref_o}));

  assert_sref_idle_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(self_ref_o) |-> (bank_open_o == '0));

  assert_lowpwr_no_cmd_R12: assert property (@(posedge clk) disable iff (rst)
    low_pwr |=> !any_pulse);

endmodule

bind lpddr_cmd_front lpddr_cmd_front_chk #(
  .NUM_BANKS (NUM_BANKS),
  .BA_W      (BA_W)
) chk_i (
  .clk         (clk),
  .rst         (rst),
  .cs_n_i      (cs_n_i),
  .act_o       (act_o),
  .rd_o        (rd_o),
  .wr_o        (wr_o),
  .pre_o       (pre_o),
  .ref_o       (ref_o),
  .mr_wr_o     (mr_wr_o),
  .emr_wr_o    (emr_wr_o),
  .illegal_o   (illegal_o),
  .cmd_bank_o  (cmd_bank_o),
  .cmd_ap_o    (cmd_ap_o),
  .bank_open_o (bank_open_o),
  .pd_pre_o    (pd_pre_o),
  .pd_act_o    (pd_act_o),
  .self_ref_o  (self_ref_o)
);

// File: tb/lpddr_cmd_front_tb.sv
module lpddr_cmd_front_tb_top;

  localparam int CLK_P = 10;
  localparam logic [2:0] P_ACT = 3'b011, P_RD = 3'b101, P_WR = 3'b100,
                         P_PRE = 3'b010, P_REF = 3'b001, P_MRS = 3'b000,
                         P_NOP = 3'b111;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cke_i = 1'b1, cs_n_i = 1'b1, ras_n_i = 1'b1, cas_n_i = 1'b1, we_n_i = 1'b1;
  logic [1:0]  ba_i = '0;
  logic [12:0] addr_i = '0;
  logic act_o, rd_o, wr_o, pre_o, ref_o, mr_wr_o, emr_wr_o, illegal_o;
  logic [1:0]  cmd_bank_o;
  logic [12:0] cmd_addr_o;
  logic [8:0]  cmd_col_o;
  logic        cmd_ap_o;
  logic [3:0]  bank_open_o;
  logic [51:0] open_rows_o;
  logic pd_pre_o, pd_act_o, self_ref_o;

  int n_chk = 0;
  int n_bad = 0;

  // reference model state
  bit          m_open [4];
  logic [12:0] m_row  [4];
  int          m_cnt  [4];
  logic [2:0]  m_bl = 3'd1;
  int          m_pw = 0;  // 0 run, 1 pd-pre, 2 pd-act, 3 self refresh
  bit e_act, e_rd, e_wr, e_pre, e_ref, e_mr, e_emr, e_ill;
  logic [1:0]  e_bank = '0;
  logic [12:0] e_addr = '0;

  always #(CLK_P/2) clk = ~clk;

  lpddr_cmd_front dut_i (
    .clk(clk), .rst(rst), .cke_i(cke_i), .cs_n_i(cs_n_i), .ras_n_i(ras_n_i),
    .cas_n_i(cas_n_i), .we_n_i(we_n_i), .ba_i(ba_i), .addr_i(addr_i),
    .act_o(act_o), .rd_o(rd_o), .wr_o(wr_o), .pre_o(pre_o), .ref_o(ref_o),
    .mr_wr_o(mr_wr_o), .emr_wr_o(emr_wr_o), .illegal_o(illegal_o),
    .cmd_bank_o(cmd_bank_o), .cmd_addr_o(cmd_addr_o), .cmd_col_o(cmd_col_o),
    .cmd_ap_o(cmd_ap_o), .bank_open_o(bank_open_o), .open_rows_o(open_rows_o),
    .pd_pre_o(pd_pre_o), .pd_act_o(pd_act_o), .self_ref_o(self_ref_o)
  );

  function automatic int burst_of(input logic [2:0] code);
    if (code == 3'd2) return 2;
    if (code == 3'd3) return 4;
    return 1;
  endfunction

  task automatic chk(input string tag, input string what, input logic [63:0] got,
                     input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, got, exp, $time);
    end
  endtask

  task automatic compare_all(input string tag);
    logic [51:0] rows;
    logic [3:0]  opn;
    for (int b = 0; b < 4; b++) begin
      rows[b*13 +: 13] = m_row[b];
      opn[b] = m_open[b];
    end
    chk(tag, "pulses", {act_o, rd_o, wr_o, pre_o, ref_o, mr_wr_o, emr_wr_o},
        {e_act, e_rd, e_wr, e_pre, e_ref, e_mr, e_emr});
    chk(tag, "illegal", illegal_o, e_ill);
    chk(tag, "fields", {cmd_bank_o, cmd_addr_o, cmd_col_o, cmd_ap_o},
        {e_bank, e_addr, e_addr[8:0], e_addr[10]});
    chk(tag, "bank_open", bank_open_o, opn);
    chk(tag, "open_rows", open_rows_o, rows);
    chk(tag, "power", {pd_pre_o, pd_act_o, self_ref_o},
        {m_pw == 1, m_pw == 2, m_pw == 3});
  endtask

  task automatic step(input string tag, input logic cke, input logic cs_n,
                      input logic [2:0] rcw, input logic [1:0] ba, input logic [12:0] addr);
    int  raw, cmd;
    bit  ill, anyo, ap;
    @(negedge clk);
    cke_i = cke; cs_n_i = cs_n; {ras_n_i, cas_n_i, we_n_i} = rcw; ba_i = ba; addr_i = addr;
    raw = 0;
    if (!cs_n) begin
      case (rcw)
        P_ACT: raw = 1;
        P_RD:  raw = 2;
        P_WR:  raw = 3;
        P_PRE: raw = 4;
        P_REF: raw = 5;
        P_MRS: raw = 6;
        default: raw = 0;
      endcase
    end
    cmd  = (m_pw == 0 && cke) ? raw : 0;
    ap   = addr[10];
    anyo = m_open[0] | m_open[1] | m_open[2] | m_open[3];
    ill  = (cmd == 1 && m_open[ba]) || ((cmd == 2 || cmd == 3) && !m_open[ba]);
    e_act = cmd == 1 && !ill;  e_rd = cmd == 2 && !ill;  e_wr = cmd == 3 && !ill;
    e_pre = cmd == 4;  e_ref = cmd == 5;
    e_mr  = cmd == 6 && !ba[1];  e_emr = cmd == 6 && ba[1];  e_ill = ill;
    if (cmd != 0) begin e_bank = ba; e_addr = addr; end
    for (int b = 0; b < 4; b++) begin
      if (cmd == 1 && !ill && b == ba) begin
        m_open[b] = 1; m_row[b] = addr; m_cnt[b] = 0;
      end else if (cmd == 4 && (ap || b == ba)) begin
        m_open[b] = 0; m_cnt[b] = 0;
      end else if ((cmd == 2 || cmd == 3) && !ill && ap && b == ba) begin
        m_cnt[b] = burst_of(m_bl);
      end else if (m_cnt[b] != 0) begin
        if (m_cnt[b] == 1) m_open[b] = 0;
        m_cnt[b]--;
      end
    end
    if (cmd == 6 && !ba[1]) m_bl = addr[2:0];
    if (m_pw == 0) begin
      if (!cke) m_pw = anyo ? 2 : (raw == 5 ? 3 : 1);
    end else if (cke) begin
      m_pw = 0;
    end
    @(posedge clk);
    #2;
    compare_all(tag);
  endtask

  initial begin
    for (int b = 0; b < 4; b++) begin m_open[b] = 0; m_row[b] = '0; m_cnt[b] = 0; end
    void'($urandom(32'd20240607));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    compare_all("R13");  // reset state

    step("R7", 1, 0, P_MRS, 2'b00, 13'h0003);  // mode register, burst field 3 -> 4 cycles
    step("R7", 1, 0, P_MRS, 2'b10, 13'h0123);  // extended register, burst field kept
    step("R3", 1, 0, P_ACT, 2'd1, 13'h1ABC);
    step("R8", 1, 0, P_ACT, 2'd1, 13'h0055);   // already open
    step("R8", 1, 0, P_RD,  2'd2, 13'h0011);   // idle bank
    step("R4", 1, 0, P_WR,  2'd1, 13'h0155);
    step("R2", 1, 1, P_ACT, 2'd0, 13'h0777);   // deselected
    step("R1", 1, 0, P_REF, 2'd0, 13'h0000);
    step("R3", 1, 0, P_ACT, 2'd2, 13'h0F0F);
    step("R5", 1, 0, P_PRE, 2'd1, 13'h0000);   // single bank
    step("R5", 1, 0, P_PRE, 2'd0, 13'h0400);   // all banks
    step("R3", 1, 0, P_ACT, 2'd0, 13'h0321);
    step("R6", 1, 0, P_RD,  2'd0, 13'h0409);   // auto-precharge
    for (int i = 0; i < 5; i++) step("R6", 1, 0, P_NOP, 2'd0, 13'h0000);
    step("R9",  0, 0, P_NOP, 2'd0, 13'h0000);
    step("R12", 0, 0, P_ACT, 2'd3, 13'h0001);  // ignored while down
    step("R12", 1, 0, P_ACT, 2'd3, 13'h0002);  // exit edge, ignored
    step("R10", 0, 0, P_REF, 2'd0, 13'h0000);
    step("R12", 1, 0, P_NOP, 2'd0, 13'h0000);
    step("R3",  1, 0, P_ACT, 2'd3, 13'h1234);
    step("R11", 0, 0, P_REF, 2'd0, 13'h0000);
    step("R12", 1, 0, P_PRE, 2'd0, 13'h0400);  // exit edge, ignored
    step("R5",  1, 0, P_PRE, 2'd0, 13'h0400);

    for (int i = 0; i < 3000; i++) begin
      logic cke;
      cke = (m_pw == 0) ? (($urandom % 25) != 0) : (($urandom % 2) == 0);
      step("R1", cke, ($urandom % 10) == 0, 3'($urandom), 2'($urandom), 13'($urandom));
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_P * 100000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule